// File: doc/BRIEF.md
# Subranging Flash Code Assembler

This block is the digital back end of a two-step subranging 8-bit converter, modelled as synchronous logic. One conversion passes through three comparator snapshots in a fixed order. First comes a 6-bit coarse estimator word, then an 8-bit first-flash word and last an 8-bit second-flash word. Each snapshot is a thermometer word. The block counts its ones, turns the coarse count into a sub-range select that steers the flash comparators, applies the overlap correction and builds the final 8-bit code.

Each snapshot arrives on its own valid/ready pair. Ready is high only while the sequencer waits for that snapshot, and a word is taken only in a cycle where valid and ready are both high. A source that holds valid with ready low simply waits, and its data is not sampled. The full-scale overflow flag travels with the second-flash snapshot. The result is held on the output and is marked by a one-cycle done pulse. It does not wait for a ready, so a consumer must take it on the done pulse or read the held value later.

Top module: `msf_assembler`

## Requirements
- R1: After reset, done, result, ovf_out, bubble_err and range_sel are all 0, and est_ready, msb_ready and lsb_ready are all low.
- R2: A start pulse while idle raises est_ready in the next cycle. Each accepted snapshot moves ready to the next snapshot in the order estimator, first flash, second flash. A start pulse while a conversion is in progress has no effect.
- R3: done is high for exactly one cycle. That cycle follows the clock edge at which the second-flash word is accepted. result and ovf_out stay unchanged until the next done pulse.
- R4: With n the number of ones in the accepted estimator word, range_sel becomes n-1 clamped to the range 0..3, from the cycle after acceptance. For example, 6'b000111 gives 2.
- R5: With c = n-1 and f the number of ones in the first-flash word: if f < 4, the corrected code is c-1 and the 3-bit middle field is f+4. Otherwise the corrected code is c and the middle field is f-4.
- R6: When the code is not clamped and there is no overflow, result = {corrected code[1:0], middle field[2:0], min(g,7)}, where g is the number of ones in the second-flash word. Bits 7:6, 5:3 and 2:0 hold these fields in that order.
- R7: A corrected code below 0 gives result 0.
- R8: A corrected code above 3 gives result 255.
- R9: When ovf_in is high with the accepted second-flash word, result is 255 and ovf_out is 1. Otherwise ovf_out is 0.
- R10: A word whose ones are not all at the bottom (a bubble) is still decoded by its count of ones. Any accepted word with a bubble sets bubble_err, which then stays set until reset.
- R11: Words presented with valid low, or while their ready is low, are not sampled and do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion (honoured only when idle) |
| est_valid | input | 1 | Estimator word valid |
| est_ready | output | 1 | Waiting for the estimator word |
| est_word | input | 6 | Coarse estimator thermometer word |
| msb_valid | input | 1 | First-flash word valid |
| msb_ready | output | 1 | Waiting for the first-flash word |
| msb_word | input | 8 | First-flash thermometer word |
| lsb_valid | input | 1 | Second-flash word valid |
| lsb_ready | output | 1 | Waiting for the second-flash word |
| lsb_word | input | 8 | Second-flash thermometer word |
| ovf_in | input | 1 | Full-scale overflow, sampled with the second-flash word |
| range_sel | output | 2 | Sub-range select for the comparator multiplexer |
| done | output | 1 | One-cycle pulse when result is updated |
| result | output | 8 | Assembled conversion code |
| ovf_out | output | 1 | Overflow of the last conversion |
| bubble_err | output | 1 | Sticky flag for a bubble in any accepted word |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the done pulse of one conversion and a start request for the next. The bench raises start in the cycle in which done is high and expects est_ready in the following cycle, with the finished result still held. The second pair is a bubble in the estimator word together with a clamp of the corrected code. Random words with bubbles are mixed into the stimulus, so some clamped results also set bubble_err. Both the clamp value and the sticky flag are compared against the bench's own model.

// File: rtl/msf_pkg.sv
package msf_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_EST  = 2'd1,
    PH_MSB  = 2'd2,
    PH_LSB  = 2'd3
  } phase_t;
endpackage

// File: rtl/therm_count.sv
module therm_count #(
  parameter int W = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  word,
  output logic [CW-1:0] ones,
  output logic          bubble
);
  logic [W:0] mask;

  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) begin
      ones = ones + CW'(word[i]);
    end
  end

  // a legal thermometer word is exactly a run of ones from bit 0
  assign mask   = ({{W{1'b0}}, 1'b1} << ones) - 1'b1;
  assign bubble = (mask[W-1:0] != word);
endmodule

// File: rtl/code_merge.sv
module code_merge #(
  parameter int EST_W   = 6,
  parameter int FLASH_W = 8,
  parameter int OUT_W   = 8,
  parameter int SUB_W   = 2,
  localparam int ECW    = $clog2(EST_W + 1),
  localparam int FCW    = $clog2(FLASH_W + 1),
  localparam int LOW_W  = (OUT_W - SUB_W) / 2,
  localparam int MID_W  = OUT_W - SUB_W - LOW_W,
  localparam int HALF   = FLASH_W / 2,
  localparam int SUB_MAX = (1 << SUB_W) - 1,
  localparam int LOW_MAX = (1 << LOW_W) - 1
) (
  input  logic [ECW-1:0]   est_ones,
  input  logic [FCW-1:0]   msb_ones,
  input  logic [FCW-1:0]   lsb_ones,
  input  logic             ovf,
  output logic [OUT_W-1:0] code
);
  int sub_raw;
  int sub_fix;
  int mid;
  int low;

  always_comb begin
    sub_raw = int'(est_ones) - 1;
    if (int'(msb_ones) < HALF) begin
      sub_fix = sub_raw - 1;
      mid     = int'(msb_ones) + HALF;
    end else begin
      sub_fix = sub_raw;
      mid     = int'(msb_ones) - HALF;
    end
    low = (int'(lsb_ones) > LOW_MAX) ? LOW_MAX : int'(lsb_ones);
    if (ovf)                  code = '1;
    else if (sub_fix < 0)     code = '0;
    else if (sub_fix > SUB_MAX) code = '1;
    else code = OUT_W'((sub_fix << (MID_W + LOW_W)) + (mid << LOW_W) + low);
  end
endmodule

// File: rtl/msf_assembler.sv
module msf_assembler
  import msf_pkg::*;
#(
  parameter int EST_W   = 6,
  parameter int FLASH_W = 8,
  parameter int OUT_W   = 8,
  parameter int SUB_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               est_valid,
  output logic               est_ready,
  input  logic [EST_W-1:0]   est_word,
  input  logic               msb_valid,
  output logic               msb_ready,
  input  logic [FLASH_W-1:0] msb_word,
  input  logic               lsb_valid,
  output logic               lsb_ready,
  input  logic [FLASH_W-1:0] lsb_word,
  input  logic               ovf_in,
  output logic [SUB_W-1:0]   range_sel,
  output logic               done,
  output logic [OUT_W-1:0]   result,
  output logic               ovf_out,
  output logic               bubble_err
);
  localparam int ECW     = $clog2(EST_W + 1);
  localparam int FCW     = $clog2(FLASH_W + 1);
  localparam int SUB_MAX = (1 << SUB_W) - 1;

  phase_t           phase;
  logic [ECW-1:0]   est_ones, est_q;
  logic [FCW-1:0]   msb_ones, msb_q, lsb_ones;
  logic             est_bub, msb_bub, lsb_bub;
  logic [OUT_W-1:0] merged;
  logic [SUB_W-1:0] sel_next;

  therm_count #(.W(EST_W))   u_est (.word(est_word), .ones(est_ones), .bubble(est_bub));
  therm_count #(.W(FLASH_W)) u_msb (.word(msb_word), .ones(msb_ones), .bubble(msb_bub));
  therm_count #(.W(FLASH_W)) u_lsb (.word(lsb_word), .ones(lsb_ones), .bubble(lsb_bub));

  code_merge #(.EST_W(EST_W), .FLASH_W(FLASH_W), .OUT_W(OUT_W), .SUB_W(SUB_W)) u_merge (
    .est_ones(est_q), .msb_ones(msb_q), .lsb_ones(lsb_ones), .ovf(ovf_in), .code(merged)
  );

  always_comb begin
    if (est_ones == '0)                  sel_next = '0;
    else if (int'(est_ones) - 1 > SUB_MAX) sel_next = SUB_W'(SUB_MAX);
    else                                 sel_next = SUB_W'(int'(est_ones) - 1);
  end

  assign est_ready = (phase == PH_EST);
  assign msb_ready = (phase == PH_MSB);
  assign lsb_ready = (phase == PH_LSB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      est_q      <= '0;
      msb_q      <= '0;
      range_sel  <= '0;
      done       <= 1'b0;
      result     <= '0;
      ovf_out    <= 1'b0;
      bubble_err <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) phase <= PH_EST;
        PH_EST: if (est_valid) begin
          est_q      <= est_ones;
          range_sel  <= sel_next;
          bubble_err <= bubble_err | est_bub;
          phase      <= PH_MSB;
        end
        PH_MSB: if (msb_valid) begin
          msb_q      <= msb_ones;
          bubble_err <= bubble_err | msb_bub;
          phase      <= PH_LSB;
        end
        PH_LSB: if (lsb_valid) begin
          result     <= merged;
          ovf_out    <= ovf_in;
          bubble_err <= bubble_err | lsb_bub;
          done       <= 1'b1;
          phase      <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msf_checker.sv
module msf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       est_ready,
  input logic       est_valid,
  input logic       msb_ready,
  input logic       lsb_valid,
  input logic       lsb_ready,
  input logic       done,
  input logic [7:0] result,
  input logic       ovf_out,
  input logic       bubble_err
);
  AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({est_ready, msb_ready, lsb_ready})); // R2
  AST_EST_TO_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (est_valid && est_ready) |=> msb_ready); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_DONE_AFTER_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (lsb_valid && lsb_ready) |=> done); // R3
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result)); // R3
  AST_OVF_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ovf_out) |-> (result == 8'hFF)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_err |=> bubble_err); // R10
endmodule

bind msf_assembler msf_checker u_chk (.*);

// File: tb/sim_msf_assembler.sv
module sim_msf_assembler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       est_valid = 1'b0, msb_valid = 1'b0, lsb_valid = 1'b0;
  logic [5:0] est_word = '0;
  logic [7:0] msb_word = '0, lsb_word = '0;
  logic       ovf_in = 1'b0;
  logic       est_ready, msb_ready, lsb_ready, done, ovf_out, bubble_err;
  logic [1:0] range_sel;
  logic [7:0] result;

  int n_chk = 0;
  int n_bad = 0;
  bit exp_err = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  msf_assembler u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ones(input logic [7:0] w);
    int c = 0;
    for (int i = 0; i < 8; i++) c += int'(w[i]);
    return c;
  endfunction

  function automatic bit is_bubble(input logic [7:0] w);
    return w != 8'((1 << ones(w)) - 1);
  endfunction

  function automatic int exp_sel(input logic [5:0] e);
    int c = ones({2'b00, e}) - 1;
    return c < 0 ? 0 : (c > 3 ? 3 : c);
  endfunction

  function automatic int exp_code(input logic [5:0] e, input logic [7:0] m,
                                  input logic [7:0] l, input bit o);
    int c = ones({2'b00, e}) - 1;
    int f = ones(m);
    int g = ones(l);
    int mid;
    if (f < 4) begin c = c - 1; mid = f + 4; end
    else mid = f - 4;
    if (g > 7) g = 7;
    if (o) return 255;          // R9
    if (c < 0) return 0;        // R7
    if (c > 3) return 255;      // R8
    return c * 64 + mid * 8 + g; // R6
  endfunction

  // one conversion; chain=1 raises start in the done cycle for the next one
  task automatic conv(input logic [5:0] e, input logic [7:0] m, input logic [7:0] l,
                      input bit o, input int stall, input bit skip_start, input bit chain);
    int exp;
    int prev;
    if (!skip_start) begin
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    chk(est_ready === 1'b1, "R2", int'(est_ready), 1);
    prev = int'(result);
    for (int s = 0; s < stall; s++) begin
      est_word = ~e; start = 1'b1;  // R11: valid low, start ignored while busy
      @(negedge clk); start = 1'b0;
      chk(est_ready === 1'b1 && result == 8'(prev), "R11", int'(result), prev);
    end
    est_valid = 1'b1; est_word = e;
    @(negedge clk); est_valid = 1'b0;
    chk(range_sel == 2'(exp_sel(e)), "R4", int'(range_sel), exp_sel(e));
    chk(msb_ready === 1'b1, "R2", int'(msb_ready), 1);
    lsb_valid = 1'b1; lsb_word = 8'hA5; // R11: ready low, not sampled
    @(negedge clk); lsb_valid = 1'b0;
    chk(msb_ready === 1'b1 && done === 1'b0, "R11", int'(msb_ready), 1);
    msb_valid = 1'b1; msb_word = m;
    @(negedge clk); msb_valid = 1'b0;
    lsb_valid = 1'b1; lsb_word = l; ovf_in = o;
    exp = exp_code(e, m, l, o);
    exp_err |= is_bubble({2'b00, e}) | is_bubble(m) | is_bubble(l);
    @(negedge clk); lsb_valid = 1'b0; ovf_in = 1'b0;
    chk(done === 1'b1, "R3", int'(done), 1);
    chk(result == 8'(exp), "R5 R6 R7 R8", int'(result), exp);
    chk(ovf_out == o, "R9", int'(ovf_out), int'(o));
    chk(bubble_err == exp_err, "R10", int'(bubble_err), int'(exp_err));
    if (chain) start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done === 1'b0 && result == 8'(exp), "R3", int'(result), exp);
    if (chain) chk(est_ready === 1'b1, "R2", int'(est_ready), 1);
  endtask

  function automatic logic [7:0] rnd_therm(input int w);
    int n = int'($urandom_range(w));
    if ($urandom_range(7) == 0) return 8'($urandom) & 8'((1 << w) - 1);
    return 8'((1 << n) - 1);
  endfunction

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    chk(done === 0 && result === 0 && ovf_out === 0 && bubble_err === 0 &&
        range_sel === 0, "R1", int'(result), 0);
    chk(est_ready === 0 && msb_ready === 0 && lsb_ready === 0, "R1", int'(est_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(est_ready === 0, "R1", int'(est_ready), 0);
    // directed: 000111 estimator, lower and upper overlap halves
    conv(6'b000111, 8'b00000011, 8'b00011111, 0, 1, 0, 0); // 117
    conv(6'b000111, 8'b00111111, 8'b00011111, 0, 0, 0, 1); // 149
    conv(6'b000000, 8'b00011111, 8'hFF, 0, 2, 1, 0);      // clamp low
    conv(6'b111111, 8'b00001111, 8'h00, 0, 0, 0, 0);      // clamp high
    conv(6'b001111, 8'b00001111, 8'h07, 1, 0, 0, 0);      // overflow
    conv(6'b000101, 8'b11111111, 8'hFF, 0, 0, 0, 1);      // bubble
    for (int k = 0; k < 300; k++) begin
      conv(6'(rnd_therm(6)), rnd_therm(8), rnd_therm(8), $urandom_range(15) == 0,
           int'($urandom_range(2)), (k == 0), k % 5 == 0);
    end
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule